// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers the reset requests of a system-on-chip and turns them into separate active-low reset outputs, one per reset domain: emulation logic, test logic, memory, clock and power control, the DSP CPU, and a set of peripheral modules. The requests are:

- an active-low power-on pin;
- an active-low warm reset pin;
- an active-low test-port reset pin;
- a watchdog request;
- two emulator requests, one for a maximum reset and one for a system reset;
- one software reset bit per module;
- a software request to reset the DSP core.

Each source reaches its own subset of domains. Every domain output goes low at once, without waiting for a clock edge. It is released in step with the clock, through a two-flop synchronizer followed by a fixed hold time.

When the memory domain comes out of a power-on or warm reset, the block pulses a capture strobe for one cycle. On that pulse it stores the boot and configuration pins. A maximum reset or a system reset never recaptures these pins. A small cause register records which chip-level source acted most recently. Only power-on reset clears it.

Top module: `reset_domain_ctrl`

## Requirements
- R1: A low power-on pin drives every domain output low, including the emulation and test outputs, and sets the cause output to 0.
- R2: The test output is low whenever the test-port reset pin or the power-on pin is low. A low test-port pin alone touches no other output.
- R3: A low warm pin drives the memory, clock/power, DSP and all module outputs low. It leaves the emulation and test outputs high.
- R4: A watchdog request or an emulator maximum request drives the same outputs low as warm reset. Neither one raises the capture strobe or changes the captured configuration.
- R5: An emulator system request drives only the DSP and the module outputs low. Memory and clock/power stay high, and the captured configuration does not change.
- R6: Module request bit i drives only module output i low.
- R7: The DSP request drives only the DSP output low.
- R8: Every output goes low as soon as one of its sources becomes active, before any clock edge.
- R9: An output rises on the 11th rising clock edge after its last active source is removed: 2 synchronizer stages, 8 hold cycles and an output register. It is still low after the 10th edge.
- R10: When several sources overlap on a domain, the release is timed from the last of them to be removed.
- R11: The capture strobe is high for exactly one cycle. That cycle is the one in which the memory output rises after an episode that included power-on or warm reset. The configuration output shows the pins sampled at the end of that cycle.
- R12: The cause output encodes 0 for power-on, 1 for warm, 2 for watchdog, 3 for emulator maximum and 4 for emulator system. It keeps the most recent source seen. When sources are active together, the priority is warm, then watchdog, then emulator maximum, then emulator system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock |
| por_n_i | input | 1 | Power-on reset pin, active low |
| warm_n_i | input | 1 | Warm reset pin, active low |
| tst_n_i | input | 1 | Test-port reset pin, active low |
| wdog_req_i | input | 1 | Watchdog reset request, active high |
| emu_max_req_i | input | 1 | Emulator maximum reset request, active high |
| emu_sys_req_i | input | 1 | Emulator system reset request, active high |
| mod_rst_req_i | input | NUM_MOD | Per-module software reset bits, active high |
| dsp_rst_req_i | input | 1 | DSP core reset request, active high |
| cfg_pins_i | input | CFG_W | Boot and configuration pins |
| emu_rst_n_o | output | 1 | Emulation logic reset, active low |
| test_rst_n_o | output | 1 | Test logic reset, active low |
| mem_rst_n_o | output | 1 | Memory reset, active low |
| clkpwr_rst_n_o | output | 1 | Clock/power control reset, active low |
| dsp_rst_n_o | output | 1 | DSP CPU reset, active low |
| mod_rst_n_o | output | NUM_MOD | Module resets, active low |
| cfg_latch_o | output | 1 | One-cycle configuration capture strobe |
| cfg_q_o | output | CFG_W | Captured configuration pins |
| cause_o | output | 3 | Most recent chip-level reset source |

## Verification
The assertions assume that the watchdog, emulator and software requests are synchronous to the domain clock. They also assume that a pin, once asserted, stays low for at least one full clock period, so that both the domain logic and the cause synchronizer see it. The hold-window check counts quiet cycles from the ports and is disabled while the power-on pin is low. The bench changes every input on the falling clock edge and holds each pulse for one or more whole periods. It keeps the configuration pins steady around each capture strobe.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [2:0] {
    CAUSE_POR     = 3'd0,
    CAUSE_WARM    = 3'd1,
    CAUSE_WDOG    = 3'd2,
    CAUSE_EMU_MAX = 3'd3,
    CAUSE_EMU_SYS = 3'd4
  } cause_e;

  // fixed domain slots ahead of the module slots
  localparam int unsigned DOM_EMU    = 0;
  localparam int unsigned DOM_TEST   = 1;
  localparam int unsigned DOM_MEM    = 2;
  localparam int unsigned DOM_CLKPWR = 3;
  localparam int unsigned DOM_DSP    = 4;
  localparam int unsigned DOM_FIXED  = 5;

endpackage

// File: rtl/rdom_stretch.sv
// One reset domain: asynchronous assertion, two-flop synchronous release,
// then HOLD_CYC extra cycles before the registered output rises.
module rdom_stretch #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic req_i,
  output logic rst_n_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLD_CYC);

  logic             arst_n;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             out_q, out_d;

  assign arst_n = ~req_i;

  always_comb begin
    cnt_en = sync_q[1] && (cnt_q != CNT_END);
    cnt_d  = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    out_d = sync_q[1] && (cnt_q == CNT_END);
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign rst_n_o = out_q;

endmodule

// File: rtl/cfg_capture.sv
// Boot/config capture: armed by power-on or warm reset, fires once when
// the memory domain leaves reset.
module cfg_capture #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic             pw_n_i,
  input  logic             dom_rst_n_i,
  input  logic [CFG_W-1:0] pins_i,
  output logic             strobe_o,
  output logic [CFG_W-1:0] cfg_o
);

  logic             pend_q, pend_d;
  logic             prev_q;
  logic             strobe;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    strobe = dom_rst_n_i && !prev_q && pend_q;
    pend_d = pend_q;
    if (strobe) begin
      pend_d = 1'b0;
    end
  end

  // armed asynchronously by either relatching source
  always_ff @(posedge clk_i or negedge pw_n_i) begin
    if (!pw_n_i) begin
      pend_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= dom_rst_n_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (strobe) begin
      cfg_q <= pins_i;
    end
  end

  assign strobe_o = strobe;
  assign cfg_o    = cfg_q;

endmodule

// File: rtl/cause_track.sv
module cause_track
  import rstc_pkg::*;
(
  input  logic   clk_i,
  input  logic   por_n_i,
  input  logic   warm_n_i,
  input  logic   wdog_i,
  input  logic   emax_i,
  input  logic   esys_i,
  output cause_e cause_o
);

  logic [1:0] wsync_q;
  cause_e     cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (!wsync_q[1])  cause_d = CAUSE_WARM;
    else if (wdog_i)  cause_d = CAUSE_WDOG;
    else if (emax_i)  cause_d = CAUSE_EMU_MAX;
    else if (esys_i)  cause_d = CAUSE_EMU_SYS;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      wsync_q <= 2'b11;
      cause_q <= CAUSE_POR;
    end else begin
      wsync_q <= {wsync_q[0], warm_n_i};
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/reset_domain_ctrl.sv
module reset_domain_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned NUM_MOD  = 4,
  parameter int unsigned CFG_W    = 8
) (
  input  logic               clk_i,
  input  logic               por_n_i,
  input  logic               warm_n_i,
  input  logic               tst_n_i,
  input  logic               wdog_req_i,
  input  logic               emu_max_req_i,
  input  logic               emu_sys_req_i,
  input  logic [NUM_MOD-1:0] mod_rst_req_i,
  input  logic               dsp_rst_req_i,
  input  logic [CFG_W-1:0]   cfg_pins_i,
  output logic               emu_rst_n_o,
  output logic               test_rst_n_o,
  output logic               mem_rst_n_o,
  output logic               clkpwr_rst_n_o,
  output logic               dsp_rst_n_o,
  output logic [NUM_MOD-1:0] mod_rst_n_o,
  output logic               cfg_latch_o,
  output logic [CFG_W-1:0]   cfg_q_o,
  output logic [2:0]         cause_o
);

  localparam int unsigned NUM_DOM = DOM_FIXED + NUM_MOD;

  logic               por_act, warm_act, max_act, chip_act, soft_act;
  logic               pw_n;
  logic [NUM_DOM-1:0] dom_req;
  logic [NUM_DOM-1:0] dom_rst_n;
  cause_e             cause;

  always_comb begin
    por_act  = ~por_n_i;
    warm_act = ~warm_n_i;
    max_act  = wdog_req_i | emu_max_req_i;
    chip_act = por_act | warm_act | max_act;
    soft_act = chip_act | emu_sys_req_i;
    pw_n     = por_n_i & warm_n_i;

    dom_req             = '0;
    dom_req[DOM_EMU]    = por_act;
    dom_req[DOM_TEST]   = ~(tst_n_i & por_n_i);
    dom_req[DOM_MEM]    = chip_act;
    dom_req[DOM_CLKPWR] = chip_act;
    dom_req[DOM_DSP]    = soft_act | dsp_rst_req_i;
    for (int m = 0; m < NUM_MOD; m++) begin
      dom_req[DOM_FIXED+m] = soft_act | mod_rst_req_i[m];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rdom_stretch #(.HOLD_CYC(HOLD_CYC)) u_dom (
      .clk_i   (clk_i),
      .req_i   (dom_req[d]),
      .rst_n_o (dom_rst_n[d])
    );
  end

  cfg_capture #(.CFG_W(CFG_W)) u_cfg (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .pw_n_i      (pw_n),
    .dom_rst_n_i (dom_rst_n[DOM_MEM]),
    .pins_i      (cfg_pins_i),
    .strobe_o    (cfg_latch_o),
    .cfg_o       (cfg_q_o)
  );

  cause_track u_cause (
    .clk_i    (clk_i),
    .por_n_i  (por_n_i),
    .warm_n_i (warm_n_i),
    .wdog_i   (wdog_req_i),
    .emax_i   (emu_max_req_i),
    .esys_i   (emu_sys_req_i),
    .cause_o  (cause)
  );

  assign emu_rst_n_o    = dom_rst_n[DOM_EMU];
  assign test_rst_n_o   = dom_rst_n[DOM_TEST];
  assign mem_rst_n_o    = dom_rst_n[DOM_MEM];
  assign clkpwr_rst_n_o = dom_rst_n[DOM_CLKPWR];
  assign dsp_rst_n_o    = dom_rst_n[DOM_DSP];
  assign mod_rst_n_o    = dom_rst_n[NUM_DOM-1:DOM_FIXED];
  assign cause_o        = cause;

endmodule

// File: rtl/reset_domain_ctrl_chk.sv
module reset_domain_ctrl_chk #(
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned NUM_MOD  = 4,
  parameter int unsigned CFG_W    = 8
) (
  input logic               clk_i,
  input logic               por_n_i,
  input logic               warm_n_i,
  input logic               tst_n_i,
  input logic               wdog_req_i,
  input logic               emu_max_req_i,
  input logic               emu_sys_req_i,
  input logic [NUM_MOD-1:0] mod_rst_req_i,
  input logic               dsp_rst_req_i,
  input logic               test_rst_n_o,
  input logic               mem_rst_n_o,
  input logic               clkpwr_rst_n_o,
  input logic               dsp_rst_n_o,
  input logic [NUM_MOD-1:0] mod_rst_n_o,
  input logic               cfg_latch_o
);

  // cycles since any memory-domain source was last seen active
  logic [7:0] quiet_q;
  logic       mem_src;

  assign mem_src = !por_n_i || !warm_n_i || wdog_req_i || emu_max_req_i;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      quiet_q <= '0;
    end else if (mem_src) begin
      quiet_q <= '0;
    end else if (quiet_q != 8'hFF) begin
      quiet_q <= quiet_q + 8'd1;
    end
  end

  p_test_and_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !tst_n_i |-> !test_rst_n_o);

  p_warm_domains_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !warm_n_i |-> (!mem_rst_n_o && !clkpwr_rst_n_o && !dsp_rst_n_o && (mod_rst_n_o == '0)));

  p_max_domains_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (wdog_req_i || emu_max_req_i) |->
      (!mem_rst_n_o && !clkpwr_rst_n_o && !dsp_rst_n_o && (mod_rst_n_o == '0)));

  p_sys_domains_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    emu_sys_req_i |-> (!dsp_rst_n_o && (mod_rst_n_o == '0)));

  p_mod_own_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (mod_rst_req_i != '0) |-> ((mod_rst_req_i & mod_rst_n_o) == '0));

  p_dsp_local_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    dsp_rst_req_i |-> !dsp_rst_n_o);

  p_hold_window_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(mem_rst_n_o) |-> (quiet_q >= 8'(HOLD_CYC)));

  p_strobe_pulse_r11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cfg_latch_o |=> !cfg_latch_o);

  p_strobe_release_r11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cfg_latch_o |-> mem_rst_n_o);

endmodule

bind reset_domain_ctrl reset_domain_ctrl_chk #(
  .HOLD_CYC (HOLD_CYC),
  .NUM_MOD  (NUM_MOD),
  .CFG_W    (CFG_W)
) u_chk (.*);

// File: tb/reset_domain_ctrl_bench.sv
`timescale 1ns/1ps
module reset_domain_ctrl_bench;

  localparam int unsigned NUM_MOD = 4;
  localparam int unsigned CFG_W   = 8;

  typedef struct packed {
    logic [3:0]  tag;   // requirement number
    logic [10:0] stim;  // {por,warm,tst,wdog,emax,esys,dsp,mod[3:0]} active high
    logic [8:0]  exp;   // {emu,test,mem,clkpwr,dsp,mod[3:0]} while active
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1, 11'b1000000_0000, 9'b000000000},  // R1 power-on
    '{4'd3, 11'b0100000_0000, 9'b110000000},  // R3 warm
    '{4'd2, 11'b0010000_0000, 9'b101111111},  // R2 test pin
    '{4'd4, 11'b0001000_0000, 9'b110000000},  // R4 watchdog
    '{4'd4, 11'b0000100_0000, 9'b110000000},  // R4 emulator max
    '{4'd5, 11'b0000010_0000, 9'b111100000},  // R5 emulator system
    '{4'd7, 11'b0000001_0000, 9'b111101111},  // R7 dsp only
    '{4'd6, 11'b0000000_0101, 9'b111111010},  // R6 modules 0 and 2
    '{4'd6, 11'b0000001_1000, 9'b111100111},  // R6 module 3 with dsp
    '{4'd2, 11'b0010010_0000, 9'b101100000}   // R2 test plus system
  };

  logic               clk_i = 1'b0;
  logic               por_n_i = 1'b1, warm_n_i = 1'b1, tst_n_i = 1'b1;
  logic               wdog_req_i = 1'b0, emu_max_req_i = 1'b0, emu_sys_req_i = 1'b0;
  logic [NUM_MOD-1:0] mod_rst_req_i = '0;
  logic               dsp_rst_req_i = 1'b0;
  logic [CFG_W-1:0]   cfg_pins_i = 8'hA5;
  logic               emu_rst_n_o, test_rst_n_o, mem_rst_n_o, clkpwr_rst_n_o, dsp_rst_n_o;
  logic [NUM_MOD-1:0] mod_rst_n_o;
  logic               cfg_latch_o;
  logic [CFG_W-1:0]   cfg_q_o;
  logic [2:0]         cause_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  reset_domain_ctrl #(.HOLD_CYC(8), .NUM_MOD(NUM_MOD), .CFG_W(CFG_W)) u_reset_domain_ctrl (.*);

  function automatic logic [8:0] obs();
    return {emu_rst_n_o, test_rst_n_o, mem_rst_n_o, clkpwr_rst_n_o, dsp_rst_n_o, mod_rst_n_o};
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] s);
    por_n_i       = ~s[10];
    warm_n_i      = ~s[9];
    tst_n_i       = ~s[8];
    wdog_req_i    = s[7];
    emu_max_req_i = s[6];
    emu_sys_req_i = s[5];
    dsp_rst_req_i = s[4];
    mod_rst_req_i = s[3:0];
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // wait 11 falling edges after a release, watching the strobe
  task automatic release_watch(output logic seen);
    seen = 1'b0;
    repeat (11) begin
      @(negedge clk_i);
      seen = seen | cfg_latch_o;
    end
  endtask

  initial begin
    cyc(20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    #5 por_n_i = 1'b0;
    #1 check("R1 all low on power-on", 32'(obs()), 32'h0);
    cyc(4);
    por_n_i = 1'b1;
    cyc(10);
    check("R9 still low after 10 edges", 32'(obs()), 32'h0);
    cyc(1);
    check("R9 released on edge 11", 32'(obs()), 32'h1FF);
    check("R11 strobe after power-on", 32'(cfg_latch_o), 32'h1);
    cyc(1);
    check("R11 strobe one cycle", 32'(cfg_latch_o), 32'h0);
    check("R11 captured pins", 32'(cfg_q_o), 32'hA5);
    check("R1 cause power-on", 32'(cause_o), 32'd0);

    // table walk: R8 immediate assertion, R9 release timing
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      drive(VEC[v].stim);
      #1 check($sformatf("R%0d/R8 vec %0d async", VEC[v].tag, v), 32'(obs()), 32'(VEC[v].exp));
      cyc(3);
      check($sformatf("R%0d vec %0d held", VEC[v].tag, v), 32'(obs()), 32'(VEC[v].exp));
      drive('0);
      cyc(10);
      check($sformatf("R9 vec %0d edge 10", v), 32'(obs()), 32'(VEC[v].exp));
      cyc(1);
      check($sformatf("R9 vec %0d edge 11", v), 32'(obs()), 32'h1FF);
      cyc(2);
    end

    // R3 R11 R12: one-cycle warm pulse recaptures pins
    cfg_pins_i = 8'h3C;
    warm_n_i = 1'b0;
    #1 check("R3 warm spares emu/test", 32'(obs()), 32'h180);
    cyc(1);
    warm_n_i = 1'b1;
    cyc(10);
    check("R9 warm pulse stretched", 32'(mem_rst_n_o), 32'h0);
    cyc(1);
    check("R11 strobe at warm release", 32'(cfg_latch_o), 32'h1);
    cyc(1);
    check("R11 warm captured pins", 32'(cfg_q_o), 32'h3C);
    check("R12 cause warm", 32'(cause_o), 32'd1);

    // R4 R12: watchdog, no recapture
    cfg_pins_i = 8'h0F;
    wdog_req_i = 1'b1;
    cyc(2);
    wdog_req_i = 1'b0;
    release_watch(seen);
    check("R4 watchdog no strobe", 32'(seen), 32'h0);
    cyc(1);
    check("R4 watchdog keeps config", 32'(cfg_q_o), 32'h3C);
    check("R12 cause watchdog", 32'(cause_o), 32'd2);

    // R4 R12: emulator max
    emu_max_req_i = 1'b1;
    cyc(2);
    emu_max_req_i = 1'b0;
    release_watch(seen);
    check("R4 emu max no strobe", 32'(seen), 32'h0);
    check("R4 emu max keeps config", 32'(cfg_q_o), 32'h3C);
    check("R12 cause emu max", 32'(cause_o), 32'd3);

    // R5 R12: system reset leaves memory and clock/power up
    emu_sys_req_i = 1'b1;
    #1 check("R5 system domains", 32'(obs()), 32'h1E0);
    cyc(2);
    emu_sys_req_i = 1'b0;
    release_watch(seen);
    check("R5 system no strobe", 32'(seen), 32'h0);
    check("R5 system keeps config", 32'(cfg_q_o), 32'h3C);
    check("R12 cause system", 32'(cause_o), 32'd4);

    // R12 priority: watchdog beats system in same cycle
    wdog_req_i = 1'b1;
    emu_sys_req_i = 1'b1;
    cyc(1);
    wdog_req_i = 1'b0;
    emu_sys_req_i = 1'b0;
    cyc(12);
    check("R12 priority watchdog over system", 32'(cause_o), 32'd2);

    // R10 R11: warm overlapped by watchdog, release timed from watchdog
    cfg_pins_i = 8'hC3;
    warm_n_i = 1'b0;
    cyc(2);
    wdog_req_i = 1'b1;
    cyc(1);
    warm_n_i = 1'b1;
    cyc(5);
    wdog_req_i = 1'b0;
    cyc(10);
    check("R10 overlap still low", 32'(mem_rst_n_o), 32'h0);
    cyc(1);
    check("R10 overlap released", 32'(mem_rst_n_o), 32'h1);
    check("R11 overlap strobe", 32'(cfg_latch_o), 32'h1);
    cyc(1);
    check("R11 overlap captured", 32'(cfg_q_o), 32'hC3);
    check("R12 cause last source", 32'(cause_o), 32'd2);

    // R1 R12: power-on clears cause
    por_n_i = 1'b0;
    #1 check("R1 emu low on power-on", 32'(emu_rst_n_o), 32'h0);
    cyc(2);
    por_n_i = 1'b1;
    cyc(11);
    check("R1 all released", 32'(obs()), 32'h1FF);
    check("R12 cause cleared by power-on", 32'(cause_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule